// File: doc/BRIEF.md
# Normal-Basis Binary Field Arithmetic Unit

This unit carries out the four field operations needed by elliptic-curve point arithmetic over GF(2^M): addition, squaring, multiplication and inversion. Elements are held in a normal basis, so bit i of a word is the coefficient of beta^(2^i). A single start strobe with a 2-bit opcode and two operands launches an operation. The unit returns its answer on a result register together with a one-cycle done pulse. Addition and squaring finish on the edge that accepts them. Multiplication is digit-serial and produces DIGIT (default 4) result coefficients per clock. Inversion is an exponentiation chain that squares and multiplies, and it reuses the same multiplier.

The multiplication matrix is the parameter LAMBDA, holding the M*M coefficients of beta_0 in the products beta_i*beta_j, with bit i*M+j for the pair (i,j). When LAMBDA is left at zero, the matrix of the type-II optimal normal basis (p = 2M+1) is derived at elaboration. This lets the unit be checked exhaustively on a small field such as M = 5. A production field such as M = 163 is obtained by supplying its matrix.

Top module: `nbf_alu`

## Requirements
- R1: After reset, result is all zeros and both done and busy are low.
- R2: Opcode 2'b00 (add) accepted on an edge gives result = opa XOR opb with done high right after that same edge.
- R3: Opcode 2'b01 (square) gives result bit i = opa bit i-1 and result bit 0 = opa bit M-1, with done right after the accepting edge.
- R4: Opcode 2'b10 (multiply) gives the normal-basis product of opa and opb, where a word w stands for the sum of w[i]*beta^(2^i).
- R5: A multiply raises done ceil(M/DIGIT) rising edges after its accepting edge, and busy is high from the accepting edge until done.
- R6: done is a single-cycle pulse per accepted operation and is never high together with busy.
- R7: Opcode 2'b11 (invert) returns opa^(2^M - 2). For nonzero opa, multiplying opa by that result gives the all-ones word.
- R8: Inverting the zero word returns the zero word.
- R9: A start raised while busy is ignored: no extra done appears, and result keeps its value until the running operation completes with its own answer.
- R10: The all-ones word is the multiplicative identity: multiplying it by x returns x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch request, taken when busy is low |
| op | input | 2 | 00 add, 01 square, 10 multiply, 11 invert |
| opa | input | M | First operand, normal-basis coefficients |
| opb | input | M | Second operand (add and multiply) |
| result | output | M | Last completed answer |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A multiply or inversion is in progress |

## Verification
The hardest state to reach from the ports is the inversion chain's hand-off between its squaring runs and its multiplier calls. In that hand-off, the shared multiplier is started from a value that is being rotated in the same cycle. This path only shows up as a correct inverse when every step of the chain is right. The stimulus therefore inverts every element of the 5-bit test field. Each inverse is compared with a brute-force inverse from an independent model that expands products in the type-II trace form, and is then multiplied back through the unit to get the all-ones word. A start held high through a running multiply drives the ignore path.

// File: rtl/nbf_pkg.sv
// Package: shared encodings for the normal-basis field unit.
// Assumes opcodes arrive as a 2-bit field on the top-level op port.
package nbf_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SQR = 2'b01,
        OP_MUL = 2'b10,
        OP_INV = 2'b11
    } nbf_op_e;

    typedef enum logic [1:0] {
        MD_IDLE = 2'b00,
        MD_MUL  = 2'b01,
        MD_INV  = 2'b10
    } nbf_mode_e;

    typedef enum logic [1:0] {
        IS_IDLE = 2'b00,
        IS_SQ   = 2'b01,
        IS_WAIT = 2'b10,
        IS_FIN  = 2'b11
    } nbf_inv_st_e;

endpackage

// File: rtl/nbf_sq.sv
// Module: one field squaring in normal basis.
// Squaring moves coefficient i to position i+1 (cyclic); pure wiring.
// Assumes M >= 2.
module nbf_sq #(
    parameter int M = 5
) (
    input  logic [M-1:0] x,
    output logic [M-1:0] y
);

    // cyclic one-place rotation toward the top
    assign y = {x[M-2:0], x[M-1]};

endmodule

// File: rtl/nbf_digit_mul.sv
// Module: digit-serial normal-basis multiplier.
// Each cycle DIGIT lanes compute DIGIT consecutive product coefficients
// from rotated copies of both operands; lanes past M are masked.
// The product with the last digit merged is offered combinationally on
// pnext while last is high. Assumes DIGIT < M.
module nbf_digit_mul #(
    parameter int              M      = 5,
    parameter int              DIGIT  = 4,
    parameter logic [M*M-1:0]  LAMBDA = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [M-1:0] x,
    input  logic [M-1:0] y,
    output logic         last,
    output logic [M-1:0] pnext
);

    localparam int NDIG = (M + DIGIT - 1) / DIGIT;
    localparam int CW   = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam int P    = 2 * M + 1;

    // exponent t with beta_i = g^t + g^-t, folded into 1..M
    function automatic int trace_exp(input int i);
        int v;
        v = 1;
        for (int s = 0; s < i; s++) v = (v * 2) % P;
        if (v > M) v = P - v;
        return v;
    endfunction

    // type-II optimal normal basis matrix for coefficient 0
    function automatic logic [M*M-1:0] type2_matrix();
        logic [M*M-1:0] mat;
        mat = '0;
        for (int i = 0; i < M; i++) begin
            for (int j = 0; j < M; j++) begin
                int ti;
                int tj;
                int df;
                int sm;
                ti = trace_exp(i);
                tj = trace_exp(j);
                df = (ti - tj + P) % P;
                sm = (ti + tj) % P;
                if (df == 1 || df == P - 1 || sm == 1 || sm == P - 1)
                    mat[i*M+j] = 1'b1;
            end
        end
        return mat;
    endfunction

    localparam logic [M*M-1:0] LAM = (LAMBDA == '0) ? type2_matrix() : LAMBDA;

    logic [M-1:0]     ar;
    logic [M-1:0]     br;
    logic [M-1:0]     ar_rot;
    logic [M-1:0]     br_rot;
    logic [M-1:0]     acc;
    logic [CW-1:0]    cnt;
    logic             active;
    logic [DIGIT-1:0] lane;

    // operand rotation by one digit per cycle
    always_comb begin
        for (int i = 0; i < M; i++) begin
            ar_rot[i] = ar[(i + DIGIT) % M];
            br_rot[i] = br[(i + DIGIT) % M];
        end
    end

    // one AND/XOR tree per lane, each seeing operands shifted by its lane index
    for (genvar d = 0; d < DIGIT; d++) begin : g_lane
        logic bit_v;
        // XOR of matrix-selected products for lane d
        always_comb begin
            bit_v = 1'b0;
            for (int i = 0; i < M; i++)
                for (int j = 0; j < M; j++)
                    bit_v = bit_v ^ (LAM[i*M+j] & ar[(i + d) % M] & br[(j + d) % M]);
        end
        assign lane[d] = bit_v;
    end

    // merge the current digit into the accumulator, masking lanes past M
    always_comb begin
        pnext = acc;
        for (int d = 0; d < DIGIT; d++) begin
            if (int'(cnt) * DIGIT + d < M)
                pnext[int'(cnt) * DIGIT + d] = lane[d];
        end
    end

    assign last = active && (cnt == CW'(NDIG - 1));

    // load, step and retire the digit sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar     <= '0;
            br     <= '0;
            acc    <= '0;
            cnt    <= '0;
            active <= 1'b0;
        end else if (go) begin
            ar     <= x;
            br     <= y;
            acc    <= '0;
            cnt    <= '0;
            active <= 1'b1;
        end else if (active) begin
            ar  <= ar_rot;
            br  <= br_rot;
            acc <= pnext;
            if (last) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/nbf_inv_seq.sv
// Module: inversion sequencer, a^(2^M-2) by an exponent addition chain.
// Walks the bits of M-1 below its top bit: each bit doubles the
// exponent run k (k squarings then a multiply by the saved value), a set
// bit adds one (a squaring then a multiply by a). A final squaring ends
// it. Borrows the shared multiplier through mul_go/mul_x/mul_y.
module nbf_inv_seq
    import nbf_pkg::*;
#(
    parameter int M = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [M-1:0] a,
    output logic         mul_go,
    output logic [M-1:0] mul_x,
    output logic [M-1:0] mul_y,
    input  logic         mul_last,
    input  logic [M-1:0] mul_pnext,
    output logic         fin,
    output logic [M-1:0] res
);

    localparam int              KW     = $clog2(M) + 1;
    localparam int              TOPBIT = $clog2(M) - 1;
    localparam int              BW     = (TOPBIT > 1) ? $clog2(TOPBIT) : 1;
    localparam logic [KW-1:0]   EXPM   = KW'(M - 1);
    localparam logic [BW-1:0]   BSTART = BW'((TOPBIT > 0) ? TOPBIT - 1 : 0);

    nbf_inv_st_e   st;
    logic [M-1:0]  t;
    logic [M-1:0]  u;
    logic [M-1:0]  a_q;
    logic [M-1:0]  t_rot;
    logic [KW-1:0] k;
    logic [KW-1:0] k_step;
    logic [KW-1:0] sq;
    logic [BW-1:0] b;
    logic          sel;

    nbf_sq #(.M(M)) i_sq (.x(t), .y(t_rot));

    // next exponent run length after the pending multiply
    assign k_step = sel ? (k + 1'b1) : (k << 1);

    // multiplier request on the last squaring of a run
    assign mul_go = (st == IS_SQ) && (sq == KW'(1));
    assign mul_x  = t_rot;
    assign mul_y  = sel ? a_q : u;
    assign fin    = (st == IS_FIN);
    assign res    = t_rot;

    // chain state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= IS_IDLE;
            t   <= '0;
            u   <= '0;
            a_q <= '0;
            k   <= '0;
            sq  <= '0;
            b   <= '0;
            sel <= 1'b0;
        end else begin
            case (st)
                IS_IDLE: begin
                    if (go) begin
                        a_q <= a;
                        t   <= a;
                        u   <= a;
                        k   <= KW'(1);
                        sq  <= KW'(1);
                        sel <= 1'b0;
                        b   <= BSTART;
                        st  <= (TOPBIT == 0) ? IS_FIN : IS_SQ;
                    end
                end
                IS_SQ: begin
                    t  <= t_rot;
                    sq <= sq - 1'b1;
                    if (sq == KW'(1)) st <= IS_WAIT;
                end
                IS_WAIT: begin
                    if (mul_last) begin
                        t <= mul_pnext;
                        k <= k_step;
                        if (!sel && EXPM[b]) begin
                            sel <= 1'b1;
                            sq  <= KW'(1);
                            st  <= IS_SQ;
                        end else if (b == '0) begin
                            st <= IS_FIN;
                        end else begin
                            b   <= b - 1'b1;
                            u   <= mul_pnext;
                            sq  <= k_step;
                            sel <= 1'b0;
                            st  <= IS_SQ;
                        end
                    end
                end
                default: st <= IS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nbf_alu.sv
// Module: normal-basis GF(2^M) arithmetic unit (top).
// Add and square complete on the accepting edge; multiply and invert
// share one digit-serial multiplier. A start while busy is dropped.
// Assumes operands are held valid only in the accepting cycle.
module nbf_alu
    import nbf_pkg::*;
#(
    parameter int             M      = 5,
    parameter int             DIGIT  = 4,
    parameter logic [M*M-1:0] LAMBDA = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [M-1:0] opa,
    input  logic [M-1:0] opb,
    output logic [M-1:0] result,
    output logic         done,
    output logic         busy
);

    nbf_mode_e    mode;
    nbf_op_e      opc;
    logic         accept;
    logic [M-1:0] sq_y;
    logic         mul_go;
    logic [M-1:0] mul_x;
    logic [M-1:0] mul_y;
    logic         mul_last;
    logic [M-1:0] mul_pnext;
    logic         inv_go;
    logic         inv_mul_go;
    logic [M-1:0] inv_x;
    logic [M-1:0] inv_y;
    logic         inv_fin;
    logic [M-1:0] inv_res;

    assign opc    = nbf_op_e'(op);
    assign busy   = (mode != MD_IDLE);
    assign accept = start && !busy;
    assign inv_go = accept && (opc == OP_INV);

    // multiplier source: port operands for a multiply, sequencer otherwise
    assign mul_go = (accept && (opc == OP_MUL)) || inv_mul_go;
    assign mul_x  = (mode == MD_INV) ? inv_x : opa;
    assign mul_y  = (mode == MD_INV) ? inv_y : opb;

    nbf_sq #(.M(M)) i_sq (.x(opa), .y(sq_y));

    nbf_digit_mul #(.M(M), .DIGIT(DIGIT), .LAMBDA(LAMBDA)) i_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mul_go),
        .x     (mul_x),
        .y     (mul_y),
        .last  (mul_last),
        .pnext (mul_pnext)
    );

    nbf_inv_seq #(.M(M)) i_inv (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (inv_go),
        .a         (opa),
        .mul_go    (inv_mul_go),
        .mul_x     (inv_x),
        .mul_y     (inv_y),
        .mul_last  (mul_last),
        .mul_pnext (mul_pnext),
        .fin       (inv_fin),
        .res       (inv_res)
    );

    // operation dispatch, completion and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= MD_IDLE;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                case (opc)
                    OP_ADD: begin
                        result <= opa ^ opb;
                        done   <= 1'b1;
                    end
                    OP_SQR: begin
                        result <= sq_y;
                        done   <= 1'b1;
                    end
                    OP_MUL:  mode <= MD_MUL;
                    default: mode <= MD_INV;
                endcase
            end else if (mode == MD_MUL && mul_last) begin
                result <= mul_pnext;
                done   <= 1'b1;
                mode   <= MD_IDLE;
            end else if (mode == MD_INV && inv_fin) begin
                result <= inv_res;
                done   <= 1'b1;
                mode   <= MD_IDLE;
            end
        end
    end

endmodule

// File: rtl/nbf_alu_chk.sv
// Module: protocol and timing checker for nbf_alu, attached by bind.
// Tracks multiply latency with a counter instead of a long delay.
module nbf_alu_chk #(
    parameter int M     = 5,
    parameter int DIGIT = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op,
    input logic [M-1:0] opa,
    input logic [M-1:0] opb,
    input logic [M-1:0] result,
    input logic         done,
    input logic         busy
);

    localparam int NDIG = (M + DIGIT - 1) / DIGIT;

    logic         pend;
    int unsigned  cnt;
    logic [M-1:0] opa_up;

    assign opa_up = {opa[M-2:0], opa[M-1]};

    // edges elapsed since a multiply was taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            cnt  <= 0;
        end else if (start && !busy && op == 2'b10) begin
            pend <= 1'b1;
            cnt  <= 0;
        end else if (pend) begin
            if (done) pend <= 1'b0;
            else      cnt  <= cnt + 1;
        end
    end

    p_add_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 2'b00) |=> (done && result == $past(opa ^ opb)));

    p_sqr_rot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 2'b01) |=> (done && result == $past(opa_up)));

    p_mul_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && done) |-> (cnt == NDIG));

    p_long_op_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op[1]) |=> busy);

    p_no_done_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done || $stable(result)));

endmodule

bind nbf_alu nbf_alu_chk #(.M(M), .DIGIT(DIGIT)) i_nbf_alu_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .opa    (opa),
    .opb    (opb),
    .result (result),
    .done   (done),
    .busy   (busy)
);

// File: tb/test_nbf_alu.sv
// Directed bench for nbf_alu on GF(2^5), type-II normal basis.
module test_nbf_alu;

    localparam int M    = 5;
    localparam int NDIG = 2;
    localparam int P    = 2 * M + 1;
    localparam logic [M-1:0] ONES = '1;

    logic         clk;
    logic         rst_n;
    logic         start;
    logic [1:0]   op;
    logic [M-1:0] opa;
    logic [M-1:0] opb;
    logic [M-1:0] result;
    logic         done;
    logic         busy;

    int n_chk = 0;
    int n_bad = 0;

    nbf_alu #(.M(M), .DIGIT(4)) i_nbf_alu (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opa(opa), .opb(opb), .result(result), .done(done), .busy(busy)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // record one comparison
    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // folded exponent of basis element i in the type-II trace form
    function automatic int texp(input int i);
        int v;
        v = 1;
        for (int s = 0; s < i; s++) v = (v * 2) % P;
        if (v > M) v = P - v;
        return v;
    endfunction

    // product model: expand (g^s+g^-s)(g^t+g^-t) = e(s+t) + e(s-t)
    function automatic logic [M-1:0] mdl_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M:0]   ev;
        logic [M-1:0] c;
        ev = '0;
        for (int i = 0; i < M; i++) begin
            for (int j = 0; j < M; j++) begin
                if (a[i] && b[j]) begin
                    int s1;
                    int s2;
                    s1 = (texp(i) + texp(j)) % P;
                    s2 = (texp(i) - texp(j) + P) % P;
                    if (s1 > M) s1 = P - s1;
                    if (s2 > M) s2 = P - s2;
                    if (s1 != 0) ev[s1] = ~ev[s1];
                    if (s2 != 0) ev[s2] = ~ev[s2];
                end
            end
        end
        for (int i = 0; i < M; i++) c[i] = ev[texp(i)];
        return c;
    endfunction

    // brute-force inverse in the model
    function automatic logic [M-1:0] mdl_inv(input logic [M-1:0] a);
        for (int y = 1; y < (1 << M); y++)
            if (mdl_mul(a, M'(y)) == ONES) return M'(y);
        return '0;
    endfunction

    // issue one operation and wait for done; lat counts edges incl. accept
    task automatic run_op(input logic [1:0] o, input logic [M-1:0] a,
                          input logic [M-1:0] b, output logic [M-1:0] r,
                          output int lat);
        @(negedge clk);
        start = 1'b1; op = o; opa = a; opb = b;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 400) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        r = result;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 result after reset", int'(result), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 busy after reset", int'(busy), 0);
    endtask

    task automatic t_add();
        logic [M-1:0] r;
        int lat;
        for (int k = 0; k < 6; k++) begin
            logic [M-1:0] a;
            logic [M-1:0] b;
            a = M'(k * 7 + 3);
            b = M'(k * 13 + 9);
            run_op(2'b00, a, b, r, lat);
            chk("R2 add result", int'(r), int'(a ^ b));
            chk("R2 add latency", lat, 1);
            chk("R6 add no busy", int'(busy), 0);
        end
    endtask

    task automatic t_sqr();
        logic [M-1:0] r;
        int lat;
        for (int k = 0; k < (1 << M); k += 5) begin
            logic [M-1:0] a;
            a = M'(k);
            run_op(2'b01, a, '0, r, lat);
            chk("R3 square rotation", int'(r), int'({a[M-2:0], a[M-1]}));
            chk("R3 square latency", lat, 1);
            chk("R4 square equals self product", int'(r), int'(mdl_mul(a, a)));
        end
    endtask

    task automatic t_mul_all();
        logic [M-1:0] r;
        int lat;
        for (int a = 0; a < (1 << M); a++) begin
            for (int b = 0; b < (1 << M); b++) begin
                run_op(2'b10, M'(a), M'(b), r, lat);
                chk("R4 product", int'(r), int'(mdl_mul(M'(a), M'(b))));
            end
        end
    endtask

    task automatic t_one();
        logic [M-1:0] r;
        int lat;
        for (int x = 0; x < (1 << M); x += 3) begin
            run_op(2'b10, ONES, M'(x), r, lat);
            chk("R10 all-ones identity", int'(r), x);
        end
    endtask

    task automatic t_mul_timing();
        int lat;
        @(negedge clk);
        start = 1'b1; op = 2'b10; opa = 5'h0b; opb = 5'h16;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        chk("R5 busy after multiply accept", int'(busy), 1);
        while (!done && lat < 50) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (!done) chk("R5 busy until done", int'(busy), 1);
        end
        chk("R5 multiply latency", lat, NDIG + 1);
        chk("R6 busy low with done", int'(busy), 0);
        chk("R4 timed product", int'(result), int'(mdl_mul(5'h0b, 5'h16)));
        @(negedge clk);
        chk("R6 done single pulse", int'(done), 0);
    endtask

    task automatic t_inv_all();
        logic [M-1:0] r;
        logic [M-1:0] p;
        int lat;
        run_op(2'b11, '0, '0, r, lat);
        chk("R8 inverse of zero", int'(r), 0);
        for (int x = 1; x < (1 << M); x++) begin
            run_op(2'b11, M'(x), '0, r, lat);
            chk("R7 inverse value", int'(r), int'(mdl_inv(M'(x))));
            run_op(2'b10, M'(x), r, p, lat);
            chk("R7 operand times inverse", int'(p), int'(ONES));
        end
    endtask

    task automatic t_busy_ignore();
        int lat;
        int dones;
        @(negedge clk);
        start = 1'b1; op = 2'b10; opa = 5'h13; opb = 5'h0d;
        @(posedge clk);
        @(negedge clk);
        op = 2'b00; opa = 5'h1f; opb = 5'h01;
        lat = 1;
        dones = 0;
        while (!done && lat < 50) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = 1'b0;
        end
        if (done) dones++;
        chk("R9 result of running multiply", int'(result), int'(mdl_mul(5'h13, 5'h0d)));
        chk("R9 latency unaffected", lat, NDIG + 1);
        @(negedge clk);
        if (done) dones++;
        chk("R9 no extra done", dones, 1);
        chk("R9 result held after", int'(result), int'(mdl_mul(5'h13, 5'h0d)));
    endtask

    // watchdog: a hung run is a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        op    = 2'b00;
        opa   = '0;
        opb   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add();
        t_sqr();
        t_mul_timing();
        t_mul_all();
        t_one();
        t_inv_all();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule